// File: doc/BRIEF.md
# Virtual Segment Selector Translation Unit

This block carries out segment-register loads for a processor whose segments are described by one system-wide global segment table. Each descriptor in that table names a page directory for its segment instead of a base and a limit. A privileged load uses the supplied selector directly as an index into the global table. An unprivileged load may not do that. Its virtual selector is first looked up in a per-context virtual segment table, which yields a global selector, and only then is the descriptor fetched.

The top bit of a virtual selector picks the lookup table. When it is 0, the table named by the descriptor in segment register 0 (the code register) is used. When it is 1, the table named by register 1 (the thread-state register) is used. After a successful load, the destination register holds the translated global selector together with the fetched descriptor. Because of this, different programs can use different virtual numbers for one segment and still end up with the same register contents.

All table accesses go through one read port to memory. The memory returns data one cycle after a read is issued. A load that fails raises a fault pulse and leaves every register as it was.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every segment register holds selector 0 and descriptor 0, and `busy`, `load_done` and `load_fault` are low.
- R2: A privileged load reads the global table at `GST_BASE + selector`. Given a present descriptor, it writes that selector and the descriptor into the destination register. `load_done` is high in the cycle after the second rising edge that follows the accepting edge.
- R3: An unprivileged load whose selector has bit 7 = 0 reads the code register's virtual table at `vst_base + selector[6:0]`. Each virtual entry has a valid flag in bit 31 and a global selector in bits 7:0. The destination register receives that global selector, not the virtual one, plus the global descriptor. `load_done` follows three edges after acceptance.
- R4: An unprivileged load whose selector has bit 7 = 1 uses the thread-state register's (index 1) virtual table in the same way.
- R5: A virtual entry with bit 31 clear gives a `load_fault` pulse and leaves all registers unchanged.
- R6: A virtual index (selector bits 6:0) not below the chosen table's length (descriptor bits 30:24) gives a `load_fault` pulse and leaves all registers unchanged.
- R7: A global descriptor whose present flag (bit 31) is clear gives a `load_fault` pulse on either path and leaves all registers unchanged. `load_done` and `load_fault` are never high together.
- R8: `busy` rises on the edge that accepts a request and falls once the write-back step ends. Requests presented while `busy` is high are ignored. The memory read port is idle whenever `busy` is low.
- R9: Reloading register 0 or 1 changes which virtual table later unprivileged loads use, including a load that targets that register itself. Descriptor layout: bit 31 present, bits 30:24 table length, bits 23:12 table base, bits 11:0 page directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request, accepted when `busy` is low |
| req_priv | input | 1 | 1 = privileged load (no virtual translation) |
| req_sel | input | SEL_W | Selector supplied by the program |
| req_dst | input | DST_W | Destination segment register index |
| busy | output | 1 | A load is in progress |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | ADDR_W | Table read word address |
| mem_rd_data | input | WORD_W | Read data, valid one cycle after the strobe |
| seg_sel_o | output | NUM_SREG*SEL_W | Global selectors of all segment registers, register 0 in the low bits |
| seg_desc_o | output | NUM_SREG*WORD_W | Descriptors of all segment registers, register 0 in the low bits |
| load_done | output | 1 | One-cycle pulse: load committed |
| load_fault | output | 1 | One-cycle pulse: load refused |

## Verification
A wrong table choice or a missed translation shows up in the register bank as a selector other than the expected global one. This is visible on `seg_sel_o` in the same cycle as `load_done`, three edges after the request is accepted. A sequencer that skips or repeats a step moves the done or fault pulse off its fixed slot, so the latency checks catch it on the first load. A stale fault flag, or a write enable that leaks through, corrupts a register that should be untouched, and the full-bank comparison after every load catches that at once.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W  = 8;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;
  localparam int LEN_W  = SEL_W - 1;

  // one descriptor word: present, table length, table base, page directory
  typedef struct packed {
    logic              present;
    logic [LEN_W-1:0]  vst_len;
    logic [ADDR_W-1:0] vst_base;
    logic [ADDR_W-1:0] pdir;
  } seg_desc_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_VST_RD = 2'd1,
    ST_GST_RD = 2'd2,
    ST_WBACK  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seg_xlate_seq.sv
module seg_xlate_seq
  import seg_xlate_pkg::*;
#(
  parameter int                NUM_SREG = 4,
  parameter int                DST_W    = $clog2(NUM_SREG),
  parameter logic [ADDR_W-1:0] GST_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_priv,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [DST_W-1:0]  req_dst,
  input  logic [LEN_W-1:0]  code_len,
  input  logic [ADDR_W-1:0] code_base,
  input  logic [LEN_W-1:0]  thr_len,
  input  logic [ADDR_W-1:0] thr_base,
  input  logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [DST_W-1:0]  wr_idx,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [WORD_W-1:0] wr_desc,
  output logic              done,
  output logic              fault
);
  seq_state_t        state;
  logic              r_priv, r_flt;
  logic [SEL_W-1:0]  r_sel, r_gsel;
  logic [DST_W-1:0]  r_dst;

  logic [LEN_W-1:0]  idx, tbl_len;
  logic [ADDR_W-1:0] tbl_base;
  logic [SEL_W-1:0]  gsel;
  logic              range_bad, vst_bad;
  seg_desc_t         desc;

  assign idx  = r_sel[LEN_W-1:0];
  assign desc = seg_desc_t'(rd_data);
  assign busy = (state != ST_IDLE);

  always_comb begin
    rd_en     = 1'b0;
    rd_addr   = '0;
    wr_en     = 1'b0;
    range_bad = 1'b0;
    vst_bad   = 1'b0;
    gsel      = r_gsel;
    tbl_len   = r_sel[SEL_W-1] ? thr_len  : code_len;
    tbl_base  = r_sel[SEL_W-1] ? thr_base : code_base;
    case (state)
      ST_VST_RD: begin
        range_bad = (idx >= tbl_len);
        rd_en     = !range_bad;
        rd_addr   = tbl_base + ADDR_W'(idx);
      end
      ST_GST_RD: begin
        vst_bad = !r_priv && !r_flt && !rd_data[WORD_W-1];
        gsel    = r_priv ? r_sel : rd_data[SEL_W-1:0];
        rd_en   = !(r_flt || vst_bad);
        rd_addr = GST_BASE + ADDR_W'(gsel);
      end
      ST_WBACK: wr_en = !r_flt && desc.present;
      default: ;
    endcase
  end

  assign wr_idx  = r_dst;
  assign wr_sel  = r_gsel;
  assign wr_desc = rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      r_priv <= 1'b0;
      r_flt  <= 1'b0;
      r_sel  <= '0;
      r_gsel <= '0;
      r_dst  <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          r_priv <= req_priv;
          r_sel  <= req_sel;
          r_dst  <= req_dst;
          r_flt  <= 1'b0;
          state  <= req_priv ? ST_GST_RD : ST_VST_RD;
        end
        ST_VST_RD: begin
          r_flt <= range_bad;
          state <= ST_GST_RD;
        end
        ST_GST_RD: begin
          r_gsel <= gsel;
          r_flt  <= r_flt || vst_bad;
          state  <= ST_WBACK;
        end
        default: begin
          done  <= wr_en;
          fault <= !wr_en;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate_bank.sv
module seg_xlate_bank
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SREG = 4,
  parameter int DST_W    = $clog2(NUM_SREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [DST_W-1:0]           wr_idx,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [WORD_W-1:0]          wr_desc,
  output logic [NUM_SREG*SEL_W-1:0]  sel_flat,
  output logic [NUM_SREG*WORD_W-1:0] desc_flat
);
  for (genvar i = 0; i < NUM_SREG; i++) begin : g_sreg
    logic [SEL_W-1:0]  sel_q;
    logic [WORD_W-1:0] desc_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q  <= '0;
        desc_q <= '0;
      end else if (wr_en && (wr_idx == DST_W'(i))) begin
        sel_q  <= wr_sel;
        desc_q <= wr_desc;
      end
    end
    assign sel_flat[i*SEL_W +: SEL_W]    = sel_q;
    assign desc_flat[i*WORD_W +: WORD_W] = desc_q;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int                NUM_SREG = 4,
  parameter int                DST_W    = $clog2(NUM_SREG),
  parameter logic [ADDR_W-1:0] GST_BASE = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_priv,
  input  logic [SEL_W-1:0]           req_sel,
  input  logic [DST_W-1:0]           req_dst,
  output logic                       busy,
  output logic                       mem_rd_en,
  output logic [ADDR_W-1:0]          mem_rd_addr,
  input  logic [WORD_W-1:0]          mem_rd_data,
  output logic [NUM_SREG*SEL_W-1:0]  seg_sel_o,
  output logic [NUM_SREG*WORD_W-1:0] seg_desc_o,
  output logic                       load_done,
  output logic                       load_fault
);
  logic              wr_en;
  logic [DST_W-1:0]  wr_idx;
  logic [SEL_W-1:0]  wr_sel;
  logic [WORD_W-1:0] wr_desc;
  seg_desc_t         code_d, thr_d;

  // register 0 = code, register 1 = thread state
  assign code_d = seg_desc_t'(seg_desc_o[0 +: WORD_W]);
  assign thr_d  = seg_desc_t'(seg_desc_o[WORD_W +: WORD_W]);

  seg_xlate_seq #(.NUM_SREG(NUM_SREG), .DST_W(DST_W), .GST_BASE(GST_BASE)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_priv(req_priv), .req_sel(req_sel), .req_dst(req_dst),
    .code_len(code_d.vst_len), .code_base(code_d.vst_base),
    .thr_len(thr_d.vst_len), .thr_base(thr_d.vst_base),
    .rd_data(mem_rd_data), .busy(busy), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_desc(wr_desc),
    .done(load_done), .fault(load_fault)
  );

  seg_xlate_bank #(.NUM_SREG(NUM_SREG), .DST_W(DST_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_desc(wr_desc),
    .sel_flat(seg_sel_o), .desc_flat(seg_desc_o)
  );
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
  parameter int NUM_SREG = 4,
  parameter int SEL_W    = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_priv,
  input logic                      busy,
  input logic                      mem_rd_en,
  input logic                      load_done,
  input logic                      load_fault,
  input logic [NUM_SREG*SEL_W-1:0] seg_sel_o
);
  assert_accept_sets_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  assert_port_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en);

  assert_outcome_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(load_done && load_fault));

  assert_fault_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    load_fault |-> $stable(seg_sel_o));

  assert_priv_latency_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid && !busy && req_priv, 3) &&
     !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)) |-> (load_done || load_fault));

  assert_user_latency_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid && !busy && !req_priv, 4) &&
     !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4))
    |-> (load_done || load_fault));
endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(.NUM_SREG(NUM_SREG), .SEL_W(seg_xlate_pkg::SEL_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_priv(req_priv), .busy(busy),
  .mem_rd_en(mem_rd_en), .load_done(load_done), .load_fault(load_fault), .seg_sel_o(seg_sel_o)
);

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_priv = 1'b0;
  logic [7:0]  req_sel = '0;
  logic [1:0]  req_dst = '0;
  logic        busy, rd_en, done, fault;
  logic [11:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic [31:0]  sel_flat;
  logic [127:0] desc_flat;

  int checks = 0, fails = 0;
  logic [7:0]  m_sel [4];
  logic [31:0] m_desc[4];

  always #4 clk = ~clk;  // 125 MHz

  seg_xlate_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_priv(req_priv),
    .req_sel(req_sel), .req_dst(req_dst), .busy(busy),
    .mem_rd_en(rd_en), .mem_rd_addr(rd_addr), .mem_rd_data(rd_data),
    .seg_sel_o(sel_flat), .seg_desc_o(desc_flat),
    .load_done(done), .load_fault(fault)
  );

  // descriptor: [31] present, [30:24] table length, [23:12] table base, [11:0] page dir
  function automatic logic [31:0] gdesc(input logic [7:0] g);
    case (g)
      8'h10:   return {1'b1, 7'd4, 12'h400, 12'h111};
      8'h11:   return {1'b1, 7'd2, 12'h600, 12'h333};
      8'h20:   return {1'b1, 7'd3, 12'h500, 12'h222};
      default: return {(g < 8'hF0), 7'd0, 12'h000, 4'h0, g};
    endcase
  endfunction

  function automatic logic [31:0] vent(input logic v, input logic [7:0] g);
    return {v, 23'd0, g};
  endfunction

  function automatic logic [31:0] mem_word(input logic [11:0] a);
    if (a < 12'h100) return gdesc(a[7:0]);
    case (a)
      12'h400: return vent(1'b1, 8'h31);
      12'h401: return vent(1'b1, 8'h42);
      12'h402: return vent(1'b0, 8'h50);
      12'h403: return vent(1'b1, 8'hF3);
      12'h500: return vent(1'b1, 8'h55);
      12'h501: return vent(1'b1, 8'h66);
      12'h502: return vent(1'b1, 8'h77);
      12'h600: return vent(1'b1, 8'h99);
      12'h601: return vent(1'b1, 8'h10);
      default: return 32'h0;
    endcase
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mem_word(rd_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < 4; i++) begin
      chk(sel_flat[i*8 +: 8] == m_sel[i], req, $sformatf("sel[%0d]", i),
          32'(sel_flat[i*8 +: 8]), 32'(m_sel[i]));
      chk(desc_flat[i*32 +: 32] == m_desc[i], req, $sformatf("desc[%0d]", i),
          desc_flat[i*32 +: 32], m_desc[i]);
    end
  endtask

  task automatic do_load(input bit priv, input logic [7:0] sel, input logic [1:0] dst,
                         input bit exp_f, input logic [7:0] exp_g, input string req);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_priv = priv; req_sel = sel; req_dst = dst;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!(done || fault) && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk(fault == exp_f && done == !exp_f, req, "outcome", {30'd0, done, fault},
        {30'd0, !exp_f, exp_f});
    chk(lat == (priv ? 3 : 4), req, "latency", 32'(lat), priv ? 32'd3 : 32'd4);
    if (!exp_f) begin
      m_sel[dst]  = exp_g;
      m_desc[dst] = gdesc(exp_g);
    end
    check_bank(req);
  endtask

  // {priv, sel, dst, fault, global sel}
  localparam logic [19:0] VEC [12] = '{
    {1'b1, 8'h10, 2'd0, 1'b0, 8'h10},  // R2 code register
    {1'b1, 8'h20, 2'd1, 1'b0, 8'h20},  // R2 thread register
    {1'b0, 8'h00, 2'd2, 1'b0, 8'h31},  // R3
    {1'b0, 8'h01, 2'd3, 1'b0, 8'h42},  // R3
    {1'b0, 8'h80, 2'd2, 1'b0, 8'h55},  // R4
    {1'b0, 8'h82, 2'd3, 1'b0, 8'h77},  // R4
    {1'b0, 8'h02, 2'd2, 1'b1, 8'h00},  // R5 invalid entry
    {1'b0, 8'h04, 2'd2, 1'b1, 8'h00},  // R6 past code length
    {1'b0, 8'h83, 2'd3, 1'b1, 8'h00},  // R6 past thread length
    {1'b0, 8'h03, 2'd3, 1'b1, 8'h00},  // R7 via user path
    {1'b1, 8'hF5, 2'd2, 1'b1, 8'h00},  // R7 via kernel path
    {1'b1, 8'h33, 2'd3, 1'b0, 8'h33}   // R2
  };
  localparam string VREQ [12] = '{"R2", "R2", "R3", "R3", "R4", "R4",
                                  "R5", "R6", "R6", "R7", "R7", "R2"};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_sel[i] = '0; m_desc[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fault, "R1", "flags after reset", {29'd0, busy, done, fault}, 32'd0);
    check_bank("R1");

    for (int v = 0; v < 12; v++)
      do_load(VEC[v][19], VEC[v][18:11], VEC[v][10:9], VEC[v][8], VEC[v][7:0], VREQ[v]);

    // R9: swap the code table, then reload register 0 through itself
    do_load(1'b1, 8'h11, 2'd0, 1'b0, 8'h11, "R9");
    do_load(1'b0, 8'h00, 2'd2, 1'b0, 8'h99, "R9");
    do_load(1'b0, 8'h02, 2'd2, 1'b1, 8'h00, "R9");
    do_load(1'b0, 8'h01, 2'd0, 1'b0, 8'h10, "R9");
    do_load(1'b0, 8'h01, 2'd3, 1'b0, 8'h42, "R9");

    // R8: second request while busy is dropped
    @(negedge clk);
    req_valid = 1'b1; req_priv = 1'b1; req_sel = 8'h44; req_dst = 2'd2;
    @(negedge clk);
    chk(busy, "R8", "busy after accept", {31'd0, busy}, 32'd1);
    req_sel = 8'h20; req_dst = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(done, "R8", "first load done", {31'd0, done}, 32'd1);
    m_sel[2] = 8'h44; m_desc[2] = gdesc(8'h44);
    check_bank("R8");
    begin
      int extra = 0;
      repeat (6) begin
        @(negedge clk);
        if (done || fault || busy) extra++;
      end
      chk(extra == 0, "R8", "ignored request activity", 32'(extra), 32'd0);
    end
    check_bank("R8");

    // R1: reset again clears the bank
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin m_sel[i] = '0; m_desc[i] = '0; end
    @(negedge clk);
    chk(!busy && !done && !fault, "R1", "flags after second reset",
        {29'd0, busy, done, fault}, 32'd0);
    check_bank("R1");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule